// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block moves the CPU system clock between a slow source and a fast source in a safe order. It controls three outputs: a raised-supply select for the core regulator, the enable of the fast oscillator, and the multiplexer select that picks the system clock. Time is measured by counting pulses of a 1 kHz reference tick. Software asks for a target source with a one-cycle request strobe. The block then runs the legal sequence and raises `busy` until the sequence ends.

Going up, the supply is raised first. The block then waits for the supply to settle, starts the fast oscillator, waits for it to stabilise, and switches the clock. Going down, the clock is switched back first. The fast oscillator is then stopped, and the supply is lowered last. A build-time option declares the slow source to be an RC oscillator. With that option every supply step is removed and the supply select stays low. Software may also write the supply select directly, but only while nothing depends on it.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A request that arrives while a sequence is running is dropped. The drop is recorded in a sticky flag.

Top module: `osc_switch_seq`

## Requirements
- R1: After reset, `vsel`, `osc_hi_en`, `clk_hi_sel`, `busy` and `rejected` are all 0.
- R2: A request with `req_hi`=1 accepted while the slow clock is selected behaves as follows when `RC_SLOW`=0. `vsel` goes to 1 at the accepting clock edge. `osc_hi_en` rises only after `SETTLE_TICKS`+1 reference ticks have been counted after that edge. The first tick only aligns the count, so the full wait is at least `SETTLE_TICKS` tick periods.
- R3: `clk_hi_sel` rises exactly one cycle after the (`STAB_TICKS`+1)-th reference tick counted after `osc_hi_en` rose, and never earlier.
- R4: A request with `req_hi`=0 accepted while the fast clock is selected does three things on three consecutive cycles. `clk_hi_sel` falls at the accepting edge. `osc_hi_en` falls one cycle later. `vsel` falls one cycle after that, and only when `RC_SLOW`=0.
- R5: `osc_hi_en` and `clk_hi_sel` never change on the same clock edge, and `clk_hi_sel`=1 always implies `osc_hi_en`=1.
- R6: A request for the source that is already selected changes no output and leaves `busy` at 0.
- R7: A request made while `busy`=1 changes no output and sets `rejected`. `rejected` stays set until a cycle in which `rej_clr`=1 and no new rejection occurs. A rejection wins over a clear in the same cycle.
- R8: With `RC_SLOW`=1, `vsel` stays 0 at all times and `vreg_we` has no effect. An up request enables the fast oscillator at the accepting edge, and the clock still waits `STAB_TICKS`+1 ticks as in R3.
- R9: When `RC_SLOW`=0, `vreg_we`=1 copies `vreg_d` into `vsel` only if the block is idle, the slow clock is selected, the fast oscillator is off and `req`=0. Otherwise the write is ignored.
- R10: `busy` is 1 from the accepting edge of a request that starts a sequence until the edge that makes the last output change of that sequence, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at 1 kHz |
| req | input | 1 | Request strobe for a clock source change |
| req_hi | input | 1 | Target source: 1 = fast, 0 = slow |
| rej_clr | input | 1 | Clears the rejected flag |
| vreg_we | input | 1 | Direct write strobe for the supply select |
| vreg_d | input | 1 | Value for the direct supply-select write |
| vsel | output | 1 | Raised-supply select |
| osc_hi_en | output | 1 | Fast oscillator enable |
| clk_hi_sel | output | 1 | System clock select: 1 = fast source |
| busy | output | 1 | A switching sequence is running |
| rejected | output | 1 | Sticky flag: a request arrived while busy |

## Verification
A wrong state in the sequencer shows at the ports in one of two ways. Either an output edge comes out of order, or the wait before it holds the wrong number of reference ticks. A scoreboard therefore records every change of the three control outputs and compares it with the next expected step. Where a wait applies, it also compares the number of ticks seen since the previous change. A bad state register or a miscounted timer is caught at the very next output change, which comes within at most `STAB_TICKS`+1 tick periods. A lost rejection or an ignored write that took effect shows up at once on `rejected` or `vsel`.

// File: rtl/osw_pkg.sv
package osw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_V_SETTLE = 3'd1,
    ST_OSC_STAB = 3'd2,
    ST_DN_OSC   = 3'd3,
    ST_DN_VOLT  = 3'd4
  } osw_state_e;

endpackage

// File: rtl/osw_tick_timer.sv
// Counts reference ticks while running; done when the count meets the limit.
module osw_tick_timer #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [WIDTH-1:0] limit,
  output logic             done
);

  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || clear) begin
      cnt <= '0;
    end else if (tick && (cnt != limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == limit);

endmodule

// File: rtl/osw_sticky_flag.sv
// Sticky status bit; set has priority over clear.
module osw_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (set) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/osw_seq_fsm.sv
// Ordering engine for supply, oscillator enable and clock select.
module osw_seq_fsm
  import osw_pkg::*;
#(
  parameter bit RC_SLOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_hi,
  input  logic vreg_we,
  input  logic vreg_d,
  input  logic tmr_done,
  output logic vsel,
  output logic osc_en,
  output logic clk_sel,
  output logic busy,
  output logic rej_set,
  output logic tmr_run,
  output logic in_settle
);

  osw_state_e state;
  logic       vsel_q;
  logic       go_up;
  logic       go_dn;
  logic       wr_ok;

  assign busy      = (state != ST_IDLE);
  assign rej_set   = req && busy;
  assign in_settle = (state == ST_V_SETTLE);
  assign tmr_run   = (state == ST_V_SETTLE) || (state == ST_OSC_STAB);

  assign go_up = req && req_hi && !clk_sel;
  assign go_dn = req && !req_hi && clk_sel;
  assign wr_ok = vreg_we && !req && !clk_sel && !osc_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vsel_q  <= 1'b0;
      osc_en  <= 1'b0;
      clk_sel <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go_up) begin
            if (RC_SLOW) begin
              osc_en <= 1'b1;
              state  <= ST_OSC_STAB;
            end else begin
              vsel_q <= 1'b1;
              state  <= ST_V_SETTLE;
            end
          end else if (go_dn) begin
            clk_sel <= 1'b0;
            state   <= ST_DN_OSC;
          end else if (wr_ok && !RC_SLOW) begin
            vsel_q <= vreg_d;
          end
        end
        ST_V_SETTLE: begin
          if (tmr_done) begin
            osc_en <= 1'b1;
            state  <= ST_OSC_STAB;
          end
        end
        ST_OSC_STAB: begin
          if (tmr_done) begin
            clk_sel <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_DN_OSC: begin
          osc_en <= 1'b0;
          state  <= RC_SLOW ? ST_IDLE : ST_DN_VOLT;
        end
        ST_DN_VOLT: begin
          vsel_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  generate
    if (RC_SLOW) begin : g_rc
      assign vsel = 1'b0;
    end else begin : g_xtal
      assign vsel = vsel_q;
    end
  endgenerate

endmodule

// File: rtl/osc_switch_seq.sv
module osc_switch_seq #(
  parameter int SETTLE_TICKS = 3,
  parameter int STAB_TICKS   = 6,
  parameter bit RC_SLOW      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic req,
  input  logic req_hi,
  input  logic rej_clr,
  input  logic vreg_we,
  input  logic vreg_d,
  output logic vsel,
  output logic osc_hi_en,
  output logic clk_hi_sel,
  output logic busy,
  output logic rejected
);

  localparam int MAX_WAIT = ((SETTLE_TICKS > STAB_TICKS) ? SETTLE_TICKS : STAB_TICKS) + 1;
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam logic [TW-1:0] LIM_SETTLE = TW'(SETTLE_TICKS + 1);
  localparam logic [TW-1:0] LIM_STAB   = TW'(STAB_TICKS + 1);

  logic          tmr_done;
  logic          tmr_run;
  logic          in_settle;
  logic          rej_set;
  logic [TW-1:0] tmr_limit;

  assign tmr_limit = in_settle ? LIM_SETTLE : LIM_STAB;

  osw_seq_fsm #(.RC_SLOW(RC_SLOW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_hi    (req_hi),
    .vreg_we   (vreg_we),
    .vreg_d    (vreg_d),
    .tmr_done  (tmr_done),
    .vsel      (vsel),
    .osc_en    (osc_hi_en),
    .clk_sel   (clk_hi_sel),
    .busy      (busy),
    .rej_set   (rej_set),
    .tmr_run   (tmr_run),
    .in_settle (in_settle)
  );

  osw_tick_timer #(.WIDTH(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .clear (tmr_done),
    .tick  (ref_tick),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  osw_sticky_flag u_rej (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (rej_set),
    .clr   (rej_clr),
    .q     (rejected)
  );

endmodule

// File: rtl/osc_switch_seq_chk.sv
module osc_switch_seq_chk #(
  parameter int SETTLE_TICKS = 3,
  parameter int STAB_TICKS   = 6,
  parameter bit RC_SLOW      = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic rej_clr,
  input logic req,
  input logic vsel,
  input logic osc_hi_en,
  input logic clk_hi_sel,
  input logic busy,
  input logic rejected
);

  logic [15:0] ticks_v;
  logic [15:0] ticks_s;

  always_ff @(posedge clk) begin
    if (!rst_n || !vsel || osc_hi_en) begin
      ticks_v <= '0;
    end else if (ref_tick && ticks_v != 16'hFFFF) begin
      ticks_v <= ticks_v + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !osc_hi_en || clk_hi_sel) begin
      ticks_s <= '0;
    end else if (ref_tick && ticks_s != 16'hFFFF) begin
      ticks_s <= ticks_s + 16'd1;
    end
  end

  a_r2_osc_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (!RC_SLOW && $rose(osc_hi_en)) |-> (ticks_v > 16'(SETTLE_TICKS)));

  a_r3_clk_after_stab: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_hi_sel) |-> (ticks_s > 16'(STAB_TICKS)));

  a_r4_vsel_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsel) |-> (!osc_hi_en && !clk_hi_sel));

  a_r5_no_joint_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(osc_hi_en) && !$stable(clk_hi_sel)));

  a_r5_clk_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hi_sel |-> osc_hi_en);

  a_r7_rej_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rejected && !rej_clr) |=> rejected);

  a_r7_rej_on_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> rejected);

  a_r8_rc_no_supply: assert property (@(posedge clk) disable iff (!rst_n)
    RC_SLOW |-> !vsel);

endmodule

bind osc_switch_seq osc_switch_seq_chk #(
  .SETTLE_TICKS (SETTLE_TICKS),
  .STAB_TICKS   (STAB_TICKS),
  .RC_SLOW      (RC_SLOW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_tick   (ref_tick),
  .rej_clr    (rej_clr),
  .req        (req),
  .vsel       (vsel),
  .osc_hi_en  (osc_hi_en),
  .clk_hi_sel (clk_hi_sel),
  .busy       (busy),
  .rejected   (rejected)
);

// File: tb/osc_switch_seq_bench.sv
module osc_switch_seq_bench;

  localparam int ST = 3;
  localparam int SB = 6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic req = 1'b0, req_hi = 1'b0, rej_clr = 1'b0, vwe = 1'b0, vd = 1'b0;
  logic vsel, osc, csel, busy, rej;
  logic creq = 1'b0, creq_hi = 1'b0, cvwe = 1'b0, cvd = 1'b0, cclr = 1'b0;
  logic c_vsel, c_osc, c_csel, c_busy, c_rej;

  always #10 clk = ~clk;

  osc_switch_seq #(.SETTLE_TICKS(ST), .STAB_TICKS(SB), .RC_SLOW(1'b0)) u_osc_switch_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(tick), .req(req), .req_hi(req_hi),
    .rej_clr(rej_clr), .vreg_we(vwe), .vreg_d(vd), .vsel(vsel), .osc_hi_en(osc),
    .clk_hi_sel(csel), .busy(busy), .rejected(rej));

  osc_switch_seq #(.SETTLE_TICKS(ST), .STAB_TICKS(SB), .RC_SLOW(1'b1)) u_osc_switch_seq_rc (
    .clk(clk), .rst_n(rst_n), .ref_tick(tick), .req(creq), .req_hi(creq_hi),
    .rej_clr(cclr), .vreg_we(cvwe), .vreg_d(cvd), .vsel(c_vsel), .osc_hi_en(c_osc),
    .clk_hi_sel(c_csel), .busy(c_busy), .rejected(c_rej));

  int n_chk = 0;
  int n_bad = 0;
  int tdiv  = 0;

  logic [2:0] exp_q[$];
  int         exptk_q[$];
  string      exptag_q[$];
  logic [2:0] m_state = 3'b000;

  always @(negedge clk) begin
    if (tdiv == 19) begin
      tdiv = 0;
      tick = 1'b1;
    end else begin
      tdiv = tdiv + 1;
      tick = 1'b0;
    end
  end

  task automatic check_val(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(logic [2:0] v, int tk, string tag);
    if (v != m_state) begin
      exp_q.push_back(v);
      exptk_q.push_back(tk);
      exptag_q.push_back(tag);
      m_state = v;
    end
  endtask

  // Monitor: every change of {vsel,osc,csel} must match the next expected step.
  initial begin
    logic [2:0] prev;
    int tks;
    prev = 3'b000;
    tks  = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      #1;
      if ({vsel, osc, csel} != prev) begin
        if (exp_q.size() == 0) begin
          check_val("R7/R9 unexpected output change", int'({vsel, osc, csel}), int'(prev));
        end else begin
          logic [2:0] e;
          int et;
          string tg;
          e  = exp_q.pop_front();
          et = exptk_q.pop_front();
          tg = exptag_q.pop_front();
          check_val({tg, " step value"}, int'({vsel, osc, csel}), int'(e));
          if (et >= 0) check_val({tg, " tick count"}, tks, et);
        end
        prev = {vsel, osc, csel};
        tks  = 0;
      end
      if (tick) tks++;
    end
  end

  task automatic pulse_req(bit hi);
    @(negedge clk);
    req = 1'b1;
    req_hi = hi;
    @(negedge clk);
    req = 1'b0;
    #1;
  endtask

  task automatic go(bit hi);
    if (hi && !m_state[0]) begin
      push({1'b1, 2'b00}, -1, "R2 supply raise");
      push(3'b110, ST + 1, "R2 osc enable");
      push(3'b111, SB + 1, "R3 clock switch");
    end else if (!hi && m_state[0]) begin
      push(3'b110, -1, "R4 clock back");
      push(3'b100, -1, "R4 osc off");
      push(3'b000, -1, "R4 supply low");
    end
    pulse_req(hi);
    check_val("R10 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done();
    do begin
      @(negedge clk);
      #1;
    end while (busy);
    repeat (3) @(negedge clk);
    #2;
    check_val("R10 all steps seen", exp_q.size(), 0);
  endtask

  task automatic vwrite(logic d);
    @(negedge clk);
    vwe = 1'b1;
    vd = d;
    @(negedge clk);
    vwe = 1'b0;
    #1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    check_val("R1 reset vsel", int'(vsel), 0);
    check_val("R1 reset osc", int'(osc), 0);
    check_val("R1 reset clk", int'(csel), 0);
    check_val("R1 reset busy", int'(busy), 0);
    check_val("R1 reset rejected", int'(rej), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: ask for the slow clock that is already selected
    pulse_req(1'b0);
    check_val("R6 busy stays low", int'(busy), 0);
    repeat (5) @(negedge clk);
    #1;
    check_val("R6 outputs unchanged", int'({vsel, osc, csel}), 0);

    // R2/R3: full up sequence
    go(1'b1);
    wait_done();
    check_val("R3 fast clock selected", int'(csel), 1);
    check_val("R10 busy cleared", int'(busy), 0);

    // R6 on the fast side, R9 write ignored while fast
    pulse_req(1'b1);
    check_val("R6 busy stays low fast", int'(busy), 0);
    vwrite(1'b0);
    repeat (3) @(negedge clk);
    #1;
    check_val("R9 write ignored while fast", int'(vsel), 1);

    // R4: down sequence
    go(1'b0);
    wait_done();
    check_val("R4 final state", int'({vsel, osc, csel}), 0);

    // R9: direct writes when idle on slow clock
    push(3'b100, -1, "R9 write high");
    vwrite(1'b1);
    check_val("R9 write takes effect", int'(vsel), 1);
    push(3'b000, -1, "R9 write low");
    vwrite(1'b0);
    check_val("R9 write low takes effect", int'(vsel), 0);
    repeat (3) @(negedge clk);

    // R7: requests while busy; R9 write while busy
    go(1'b1);
    repeat (4) @(negedge clk);
    pulse_req(1'b0);
    check_val("R7 rejected set", int'(rej), 1);
    vwrite(1'b0);
    check_val("R9 write ignored while busy", int'(vsel), 1);
    @(negedge clk);
    req = 1'b1;
    req_hi = 1'b0;
    rej_clr = 1'b1;
    @(negedge clk);
    req = 1'b0;
    rej_clr = 1'b0;
    #1;
    check_val("R7 rejection wins over clear", int'(rej), 1);
    wait_done();
    check_val("R7 flag still sticky", int'(rej), 1);
    @(negedge clk);
    rej_clr = 1'b1;
    @(negedge clk);
    rej_clr = 1'b0;
    #1;
    check_val("R7 flag cleared", int'(rej), 0);
    go(1'b0);
    wait_done();

    // R8: RC slow-source variant
    begin
      int tk;
      bit vbad;
      bit order_bad;
      tk = 0;
      vbad = 1'b0;
      order_bad = 1'b0;
      @(negedge clk);
      cvwe = 1'b1;
      cvd = 1'b1;
      @(negedge clk);
      cvwe = 1'b0;
      #1;
      check_val("R8 write has no effect", int'(c_vsel), 0);
      @(negedge clk);
      creq = 1'b1;
      creq_hi = 1'b1;
      @(negedge clk);
      creq = 1'b0;
      #1;
      check_val("R8 osc enabled at accept", int'(c_osc), 1);
      if (tick && !c_csel) tk++;
      do begin
        @(negedge clk);
        #1;
        if (c_vsel) vbad = 1'b1;
        if (c_osc && !c_csel && tick) tk++;
      end while (c_busy);
      check_val("R8 stabilisation ticks", tk, SB + 1);
      check_val("R8 fast clock selected", int'(c_csel), 1);
      @(negedge clk);
      creq = 1'b1;
      creq_hi = 1'b0;
      @(negedge clk);
      creq = 1'b0;
      #1;
      if (!(c_osc && !c_csel)) order_bad = 1'b1;
      @(negedge clk);
      #1;
      if (c_osc || c_busy) order_bad = 1'b1;
      check_val("R8 down order", int'(order_bad), 0);
      check_val("R8 supply never raised", int'(vbad), 0);
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule